// File: doc/BRIEF.md
# Completion Interrupt Trigger Engine

This block decides, for every completion queue, when the host should be told about new work. It sees four event streams, each tagged with a queue number: a completion entry has been written, software has moved the consumer index, user logic asks for an interrupt, and a write to a queue's configuration. The block answers with an interrupt request that carries the queue's 11-bit vector, and a status-write request that carries the queue's producer index.

Each queue is either disarmed or armed. A queue starts disarmed after reset and after any configuration write, and it stays deaf to trigger conditions until software sends a consumer-index update. When a trigger fires, the queue drops back to disarmed. A user request that arrives while the queue is disarmed is remembered as a pending bit. The next consumer-index update resolves that bit. In the user-plus-timer mode, a user request starts a per-queue moderation countdown. The start value comes from a 16-entry timer table chosen by the queue's timer index.

When several queues fire in the same cycle, the lowest queue number is delivered first and the others follow one per cycle. Each output is a one-cycle pulse.

Top module: `cq_irq_trigger`

## Requirements
- R1: After reset, and after any configuration write to a queue, the queue is disarmed: it clears its pending bit, its timer, its producer and consumer indices and any undelivered request. Completion writes to a disarmed queue produce no output.
- R2: A consumer-index update arms a valid queue. In mode 1 (every entry), a completion write to an armed queue fires one cycle later with the queue's vector, and the queue disarms, so a second write produces nothing.
- R3: The mode field is 3 bits wide: 0 disabled, 1 every entry, 3 user, 4 user plus timer. Mode 0 and the reserved values 2, 5, 6 and 7 never fire on writes, user requests or updates.
- R4: In mode 3, a user request to an armed queue fires one cycle later.
- R5: In modes 3 and 4, a user request to a disarmed queue sets a pending bit and produces no output. The next consumer-index update fires in that same cycle if the producer index, counting writes in that cycle, differs from the new consumer index.
- R6: If a pending bit meets an update that leaves the producer index equal to the consumer index, the bit is dropped with no output, and the queue is still armed by that update.
- R7: In mode 4, a user request to an armed queue with no running timer loads the timer with entry V of the timer table, where V is selected by the queue's 4-bit timer index. The queue fires V+1 cycles after the request. User requests that arrive while the timer runs neither restart it nor fire.
- R8: The interrupt enable and the status enable gate their two outputs independently. A status request reports the queue number and the producer index as it stands after the firing event.
- R9: A configuration write, whether it invalidates the queue or not, discards a pending user request and stops a running timer.
- R10: A queue whose valid bit is 0 ignores writes, updates and user requests.
- R11: When several queues have requests outstanding, each output delivers the lowest-numbered queue first, one queue per cycle, and the rest in the following cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_qid_i | input | QID_W | Queue being configured |
| cfg_valid_i | input | 1 | Queue valid bit |
| cfg_mode_i | input | 3 | Trigger mode (0 off, 1 every, 3 user, 4 user+timer) |
| cfg_en_int_i | input | 1 | Interrupt enable |
| cfg_en_stat_i | input | 1 | Status-write enable |
| cfg_vec_i | input | 11 | Interrupt vector number |
| cfg_tidx_i | input | 4 | Timer table index |
| wr_evt_i | input | 1 | Completion entry written |
| wr_qid_i | input | QID_W | Queue of the written entry |
| upd_evt_i | input | 1 | Consumer-index update |
| upd_qid_i | input | QID_W | Queue of the update |
| upd_cidx_i | input | IDX_W | New consumer index |
| usr_evt_i | input | 1 | User interrupt request |
| usr_qid_i | input | QID_W | Queue of the user request |
| tmr_tbl_i | input | 16*TMR_W | Timer start values, entry k at bits k*TMR_W upward |
| irq_valid_o | output | 1 | Interrupt request pulse |
| irq_qid_o | output | QID_W | Queue of the interrupt |
| irq_vec_o | output | 11 | Vector of the interrupt |
| stat_valid_o | output | 1 | Status-write request pulse |
| stat_qid_o | output | QID_W | Queue of the status write |
| stat_pidx_o | output | IDX_W | Producer index to report |

## Verification
An event sampled at a clock edge shows its result on the outputs right after that same edge, so every request is due one cycle after its stimulus. The exceptions are a timer firing, which is due V+1 edges after the user request, and queues that collide, whose requests follow on later edges in queue order. The bench changes inputs 1 ns after a rising edge and reads the outputs 1 ns after the next rising edge. Each check is made at the one edge where its result is due, and the "no output" checks are made at every edge of a timer window and after each ignored event.

// File: rtl/cqt_pkg.sv
package cqt_pkg;

    localparam int VEC_W   = 11;
    localparam int TIDX_W  = 4;
    localparam int NUM_TMR = 1 << TIDX_W;

    localparam logic [2:0] MODE_OFF      = 3'd0;
    localparam logic [2:0] MODE_EVERY    = 3'd1;
    localparam logic [2:0] MODE_USER     = 3'd3;
    localparam logic [2:0] MODE_USER_TMR = 3'd4;

    typedef enum logic {
        ST_ISR  = 1'b0,
        ST_TRIG = 1'b1
    } arm_e;

    typedef struct packed {
        logic              valid;
        logic [2:0]        mode;
        logic              en_int;
        logic              en_stat;
        logic [VEC_W-1:0]  vec;
        logic [TIDX_W-1:0] tidx;
    } qcfg_t;

endpackage

// File: rtl/cqt_pick.sv
module cqt_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  gnt_o,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);

    always_comb begin
        gnt_o = '0;
        idx_o = '0;
        any_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IW'(i);
                any_o = 1'b1;
            end
        end
        if (any_o) begin
            gnt_o[idx_o] = 1'b1;
        end
    end

endmodule

// File: rtl/cqt_queue.sv
module cqt_queue
    import cqt_pkg::*;
#(
    parameter int IDX_W = 16,
    parameter int TMR_W = 8
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     cfg_hit_i,
    input  qcfg_t                    cfg_i,
    input  logic                     wr_hit_i,
    input  logic                     upd_hit_i,
    input  logic [IDX_W-1:0]         upd_cidx_i,
    input  logic                     usr_hit_i,
    input  logic [NUM_TMR*TMR_W-1:0] tmr_tbl_i,
    input  logic                     irq_gnt_i,
    input  logic                     stat_gnt_i,
    output logic                     irq_req_o,
    output logic                     stat_req_o,
    output logic [VEC_W-1:0]         vec_o,
    output logic [IDX_W-1:0]         pidx_o
);

    typedef struct packed {
        qcfg_t             cfg;
        arm_e              st;
        logic              pend;
        logic              trun;
        logic [TMR_W-1:0]  tcnt;
        logic [IDX_W-1:0]  pidx;
        logic [IDX_W-1:0]  cidx;
        logic              irq_req;
        logic              stat_req;
    } qst_t;

    qst_t s_d, s_q;

    logic             armed;
    logic             user_mode;
    logic             fire;
    logic             pend_fire;
    logic [TMR_W-1:0] tval;

    always_comb begin
        s_d       = s_q;
        fire      = 1'b0;
        pend_fire = 1'b0;
        armed     = (s_q.st == ST_TRIG) || upd_hit_i;
        user_mode = (s_q.cfg.mode == MODE_USER) || (s_q.cfg.mode == MODE_USER_TMR);
        tval      = tmr_tbl_i[int'(s_q.cfg.tidx) * TMR_W +: TMR_W];

        if (irq_gnt_i) begin
            s_d.irq_req = 1'b0;
        end
        if (stat_gnt_i) begin
            s_d.stat_req = 1'b0;
        end

        if (cfg_hit_i) begin
            s_d     = '0;
            s_d.cfg = cfg_i;
        end else if (s_q.cfg.valid) begin
            if (wr_hit_i) begin
                s_d.pidx = s_q.pidx + 1'b1;
            end
            if (upd_hit_i) begin
                s_d.cidx = upd_cidx_i;
                s_d.st   = ST_TRIG;
                s_d.pend = 1'b0;
                if (s_q.pend && user_mode && (s_d.pidx != s_d.cidx)) begin
                    pend_fire = 1'b1;
                end
            end

            case (s_q.cfg.mode)
                MODE_EVERY: begin
                    if (wr_hit_i && armed) begin
                        fire = 1'b1;
                    end
                end
                MODE_USER: begin
                    if (usr_hit_i) begin
                        if (armed) begin
                            fire = 1'b1;
                        end else begin
                            s_d.pend = 1'b1;
                        end
                    end
                end
                MODE_USER_TMR: begin
                    if (usr_hit_i) begin
                        if (!armed) begin
                            s_d.pend = 1'b1;
                        end else if (!s_q.trun && !pend_fire) begin
                            s_d.trun = 1'b1;
                            s_d.tcnt = tval;
                        end
                    end
                end
                default: begin
                end
            endcase

            if (s_q.trun) begin
                if (s_q.tcnt == '0) begin
                    s_d.trun = 1'b0;
                    fire     = 1'b1;
                end else begin
                    s_d.tcnt = s_q.tcnt - 1'b1;
                end
            end

            if (fire || pend_fire) begin
                s_d.st = ST_ISR;
                if (s_q.cfg.en_int) begin
                    s_d.irq_req = 1'b1;
                end
                if (s_q.cfg.en_stat) begin
                    s_d.stat_req = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_req_o  = s_q.irq_req;
    assign stat_req_o = s_q.stat_req;
    assign vec_o      = s_q.cfg.vec;
    assign pidx_o     = s_q.pidx;

    // R7: a moderation timer only runs while the queue is armed
    p_timer_armed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.trun |-> (s_q.st == ST_TRIG));

    // R5: a remembered user request only exists on a disarmed queue
    p_pend_disarmed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.pend |-> (s_q.st == ST_ISR));

    // R2: a new interrupt request leaves the queue disarmed
    p_fire_disarms_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(s_q.irq_req) |-> (s_q.st == ST_ISR));

    // R3: only modes 1, 3 and 4 of a valid queue can raise a request
    p_mode_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(s_q.irq_req) |-> (s_q.cfg.valid &&
            ((s_q.cfg.mode == MODE_EVERY) || (s_q.cfg.mode == MODE_USER) ||
             (s_q.cfg.mode == MODE_USER_TMR))));

    // R1: a configuration write leaves the queue disarmed and quiet
    p_cfg_clears_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_hit_i |=> (s_q.st == ST_ISR && !s_q.pend && !s_q.trun && !s_q.irq_req));

endmodule

// File: rtl/cq_irq_trigger.sv
module cq_irq_trigger
    import cqt_pkg::*;
#(
    parameter int NUM_Q = 8,
    parameter int IDX_W = 16,
    parameter int TMR_W = 8,
    localparam int QID_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     cfg_we_i,
    input  logic [QID_W-1:0]         cfg_qid_i,
    input  logic                     cfg_valid_i,
    input  logic [2:0]               cfg_mode_i,
    input  logic                     cfg_en_int_i,
    input  logic                     cfg_en_stat_i,
    input  logic [VEC_W-1:0]         cfg_vec_i,
    input  logic [TIDX_W-1:0]        cfg_tidx_i,
    input  logic                     wr_evt_i,
    input  logic [QID_W-1:0]         wr_qid_i,
    input  logic                     upd_evt_i,
    input  logic [QID_W-1:0]         upd_qid_i,
    input  logic [IDX_W-1:0]         upd_cidx_i,
    input  logic                     usr_evt_i,
    input  logic [QID_W-1:0]         usr_qid_i,
    input  logic [NUM_TMR*TMR_W-1:0] tmr_tbl_i,
    output logic                     irq_valid_o,
    output logic [QID_W-1:0]         irq_qid_o,
    output logic [VEC_W-1:0]         irq_vec_o,
    output logic                     stat_valid_o,
    output logic [QID_W-1:0]         stat_qid_o,
    output logic [IDX_W-1:0]         stat_pidx_o
);

    qcfg_t            cfg_w;
    logic [NUM_Q-1:0] irq_req, stat_req, irq_gnt, stat_gnt;
    logic [VEC_W-1:0] vec_a  [NUM_Q];
    logic [IDX_W-1:0] pidx_a [NUM_Q];
    logic [QID_W-1:0] irq_idx, stat_idx;
    logic             irq_any, stat_any;

    always_comb begin
        cfg_w.valid   = cfg_valid_i;
        cfg_w.mode    = cfg_mode_i;
        cfg_w.en_int  = cfg_en_int_i;
        cfg_w.en_stat = cfg_en_stat_i;
        cfg_w.vec     = cfg_vec_i;
        cfg_w.tidx    = cfg_tidx_i;
    end

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        cqt_queue #(
            .IDX_W (IDX_W),
            .TMR_W (TMR_W)
        ) u_queue (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .cfg_hit_i  (cfg_we_i  && (cfg_qid_i == QID_W'(q))),
            .cfg_i      (cfg_w),
            .wr_hit_i   (wr_evt_i  && (wr_qid_i  == QID_W'(q))),
            .upd_hit_i  (upd_evt_i && (upd_qid_i == QID_W'(q))),
            .upd_cidx_i (upd_cidx_i),
            .usr_hit_i  (usr_evt_i && (usr_qid_i == QID_W'(q))),
            .tmr_tbl_i  (tmr_tbl_i),
            .irq_gnt_i  (irq_gnt[q]),
            .stat_gnt_i (stat_gnt[q]),
            .irq_req_o  (irq_req[q]),
            .stat_req_o (stat_req[q]),
            .vec_o      (vec_a[q]),
            .pidx_o     (pidx_a[q])
        );
    end

    cqt_pick #(.N(NUM_Q), .IW(QID_W)) u_irq_pick (
        .req_i (irq_req),
        .gnt_o (irq_gnt),
        .idx_o (irq_idx),
        .any_o (irq_any)
    );

    cqt_pick #(.N(NUM_Q), .IW(QID_W)) u_stat_pick (
        .req_i (stat_req),
        .gnt_o (stat_gnt),
        .idx_o (stat_idx),
        .any_o (stat_any)
    );

    assign irq_valid_o  = irq_any;
    assign irq_qid_o    = irq_idx;
    assign irq_vec_o    = irq_any ? vec_a[irq_idx] : '0;
    assign stat_valid_o = stat_any;
    assign stat_qid_o   = stat_idx;
    assign stat_pidx_o  = stat_any ? pidx_a[stat_idx] : '0;

    // R11: at most one queue is delivered per output per cycle
    p_irq_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(irq_gnt));
    p_stat_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(stat_gnt));

    // R11: a delivered request is the lowest-numbered one outstanding
    p_irq_lowest_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_valid_o |-> ((irq_req & ((NUM_Q'(1) << irq_qid_o) - NUM_Q'(1))) == '0));

endmodule

// File: tb/tb_cq_irq_trigger.sv
module tb_cq_irq_trigger;

    localparam int NUM_Q = 8;
    localparam int IDX_W = 16;
    localparam int TMR_W = 8;
    localparam int QID_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [QID_W-1:0]  cfg_qid = '0;
    logic              cfg_valid = 1'b0;
    logic [2:0]        cfg_mode = '0;
    logic              cfg_en_int = 1'b0;
    logic              cfg_en_stat = 1'b0;
    logic [10:0]       cfg_vec = '0;
    logic [3:0]        cfg_tidx = '0;
    logic              wr_evt = 1'b0;
    logic [QID_W-1:0]  wr_qid = '0;
    logic              upd_evt = 1'b0;
    logic [QID_W-1:0]  upd_qid = '0;
    logic [IDX_W-1:0]  upd_cidx = '0;
    logic              usr_evt = 1'b0;
    logic [QID_W-1:0]  usr_qid = '0;
    logic [16*TMR_W-1:0] tmr_tbl = '0;
    logic              irq_valid;
    logic [QID_W-1:0]  irq_qid;
    logic [10:0]       irq_vec;
    logic              stat_valid;
    logic [QID_W-1:0]  stat_qid;
    logic [IDX_W-1:0]  stat_pidx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cq_irq_trigger #(.NUM_Q(NUM_Q), .IDX_W(IDX_W), .TMR_W(TMR_W)) dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .cfg_we_i     (cfg_we),
        .cfg_qid_i    (cfg_qid),
        .cfg_valid_i  (cfg_valid),
        .cfg_mode_i   (cfg_mode),
        .cfg_en_int_i (cfg_en_int),
        .cfg_en_stat_i(cfg_en_stat),
        .cfg_vec_i    (cfg_vec),
        .cfg_tidx_i   (cfg_tidx),
        .wr_evt_i     (wr_evt),
        .wr_qid_i     (wr_qid),
        .upd_evt_i    (upd_evt),
        .upd_qid_i    (upd_qid),
        .upd_cidx_i   (upd_cidx),
        .usr_evt_i    (usr_evt),
        .usr_qid_i    (usr_qid),
        .tmr_tbl_i    (tmr_tbl),
        .irq_valid_o  (irq_valid),
        .irq_qid_o    (irq_qid),
        .irq_vec_o    (irq_vec),
        .stat_valid_o (stat_valid),
        .stat_qid_o   (stat_qid),
        .stat_pidx_o  (stat_pidx)
    );

    task automatic clk1();
        @(posedge clk);
        #1;
        cfg_we  = 1'b0;
        wr_evt  = 1'b0;
        upd_evt = 1'b0;
        usr_evt = 1'b0;
    endtask

    task automatic chk(string tag, logic iv, int iq, int ivec, logic sv, int sq, int sp);
        bit bad;
        checks++;
        bad = (irq_valid !== iv) || (stat_valid !== sv);
        if (iv && ((irq_qid !== QID_W'(iq)) || (irq_vec !== 11'(ivec)))) bad = 1'b1;
        if (sv && ((stat_qid !== QID_W'(sq)) || (stat_pidx !== IDX_W'(sp)))) bad = 1'b1;
        if (bad) begin
            errors++;
            $display("FAIL %s: got irq=%0b q=%0d vec=%0d stat=%0b q=%0d pidx=%0d exp irq=%0b q=%0d vec=%0d stat=%0b q=%0d pidx=%0d",
                     tag, irq_valid, irq_qid, irq_vec, stat_valid, stat_qid, stat_pidx,
                     iv, iq, ivec, sv, sq, sp);
        end
    endtask

    task automatic chk_none(string tag);
        chk(tag, 1'b0, 0, 0, 1'b0, 0, 0);
    endtask

    task automatic cfg(int q, bit v, int mode, bit ei, bit es, int vec, int tidx);
        cfg_we = 1'b1; cfg_qid = QID_W'(q); cfg_valid = v; cfg_mode = 3'(mode);
        cfg_en_int = ei; cfg_en_stat = es; cfg_vec = 11'(vec); cfg_tidx = 4'(tidx);
        clk1();
    endtask

    task automatic wr(int q);
        wr_evt = 1'b1; wr_qid = QID_W'(q);
        clk1();
    endtask

    task automatic upd(int q, int c);
        upd_evt = 1'b1; upd_qid = QID_W'(q); upd_cidx = IDX_W'(c);
        clk1();
    endtask

    task automatic usr(int q);
        usr_evt = 1'b1; usr_qid = QID_W'(q);
        clk1();
    endtask

    task automatic t_reset_disarm();
        chk_none("R1 reset quiet");
        cfg(1, 1, 1, 1, 1, 101, 0);
        chk_none("R1 after cfg");
        wr(1);
        chk_none("R1 write to disarmed queue");
    endtask

    task automatic t_every();
        upd(1, 1);
        chk_none("R2 arm with empty ring");
        wr(1);
        chk("R2 every-entry fire", 1, 1, 101, 1, 1, 2);
        clk1();
        chk_none("R2 pulse ends");
        wr(1);
        chk_none("R2 disarmed after fire");
    endtask

    task automatic t_reserved();
        for (int m = 0; m < 8; m++) begin
            if (m == 0 || m == 2 || m >= 5) begin
                cfg(2, 1, m, 1, 1, 102, 0);
                upd(2, 0);
                wr(2);
                chk_none("R3 write in non-firing mode");
                usr(2);
                chk_none("R3 user in non-firing mode");
                usr(2);
                upd(2, 0);
                chk_none("R3 update in non-firing mode");
            end
        end
    endtask

    task automatic t_user();
        cfg(3, 1, 3, 1, 1, 103, 0);
        upd(3, 0);
        chk_none("R4 arm");
        usr(3);
        chk("R4 user fire", 1, 3, 103, 1, 3, 0);
    endtask

    task automatic t_pend_fire();
        cfg(0, 1, 3, 1, 1, 100, 0);
        usr(0);
        chk_none("R5 user while disarmed");
        wr(0);
        wr(0);
        chk_none("R5 writes while pending");
        upd(0, 0);
        chk("R5 pending resolves to fire", 1, 0, 100, 1, 0, 2);
    endtask

    task automatic t_pend_empty();
        usr(0);
        chk_none("R6 pend again");
        upd(0, 2);
        chk_none("R6 empty ring drops pending");
        usr(0);
        chk("R6 queue armed by update", 1, 0, 100, 1, 0, 2);
    endtask

    task automatic t_timer();
        tmr_tbl[5*TMR_W +: TMR_W] = 8'd3;
        cfg(3, 1, 4, 1, 1, 103, 5);
        upd(3, 0);
        usr(3);
        chk_none("R7 timer started");
        clk1();
        chk_none("R7 timer cycle 1");
        usr(3);
        chk_none("R7 user ignored while running");
        clk1();
        chk_none("R7 timer cycle 3");
        clk1();
        chk("R7 timer expiry", 1, 3, 103, 1, 3, 0);
        clk1();
        clk1();
        clk1();
        chk_none("R7 timer not restarted");
    endtask

    task automatic t_enables();
        cfg(4, 1, 1, 0, 1, 104, 0);
        upd(4, 0);
        wr(4);
        chk("R8 status only", 0, 0, 0, 1, 4, 1);
        cfg(4, 1, 1, 1, 0, 104, 0);
        upd(4, 0);
        wr(4);
        chk("R8 interrupt only", 1, 4, 104, 0, 0, 0);
    endtask

    task automatic t_invalidate();
        cfg(6, 1, 3, 1, 1, 106, 0);
        usr(6);
        wr(6);
        cfg(6, 0, 3, 1, 1, 106, 0);
        cfg(6, 1, 3, 1, 1, 106, 0);
        wr(6);
        upd(6, 0);
        chk_none("R9 pending discarded by invalidation");
        cfg(7, 1, 4, 1, 1, 107, 5);
        upd(7, 0);
        usr(7);
        cfg(7, 1, 4, 1, 1, 107, 5);
        for (int i = 0; i < 6; i++) begin
            clk1();
            chk_none("R9 timer stopped by cfg write");
        end
    endtask

    task automatic t_invalid_ignored();
        cfg(5, 0, 3, 1, 1, 105, 0);
        upd(5, 0);
        usr(5);
        chk_none("R10 invalid queue ignores user");
        cfg(5, 0, 1, 1, 1, 105, 0);
        upd(5, 0);
        wr(5);
        chk_none("R10 invalid queue ignores write");
    endtask

    task automatic t_collide();
        cfg(1, 1, 1, 1, 1, 101, 0);
        cfg(2, 1, 3, 1, 1, 102, 0);
        upd(1, 0);
        upd(2, 0);
        wr_evt = 1'b1; wr_qid = 3'd1;
        usr_evt = 1'b1; usr_qid = 3'd2;
        clk1();
        chk("R11 lowest first", 1, 1, 101, 1, 1, 1);
        clk1();
        chk("R11 second queue next", 1, 2, 102, 1, 2, 0);
        clk1();
        chk_none("R11 drained");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset_disarm();
        t_every();
        t_reserved();
        t_user();
        t_pend_fire();
        t_pend_empty();
        t_timer();
        t_enables();
        t_invalidate();
        t_invalid_ignored();
        t_collide();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got running exp finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule